// File: doc/BRIEF.md
# Virtual Channel Claim and Release Controller

This block sits at one output port of a network-on-chip router. It keeps track of which virtual channels (VCs) are currently held by packets that are still passing through. Each incoming flit carries a 2-bit kind code, a VC number, a packet tag and a payload. A header flit takes the lowest-numbered free VC and records its packet tag as the owner. Body and tail flits pass only when the VC they name is held by their own packet. A tail also releases the VC. A single-flit packet passes without touching any VC.

Any flit that cannot proceed is sent back to its input VC through a push-back strobe. Every decision is registered. Exactly one cycle after a flit is accepted, either the forward output or the push-back output is valid. The ownership state is published as a per-VC busy vector.

Top module: `vcs_signup_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `busy` is all zeros and `fwd_valid` and `push_back` are 0. `in_ready` is 0 during reset and 1 afterwards.
- R2: Kind code 01 is a header. An accepted header, when any VC is free, is forwarded with `fwd_vc` equal to the lowest-numbered free VC. That VC's busy bit sets on the same edge, and the header's tag is stored as the VC's owner.
- R3: An accepted header that finds every VC busy is pushed back, and `busy` does not change.
- R4: Kind code 10 is a body. An accepted body whose `in_vc` is busy and owned by `in_tag` is forwarded with `fwd_vc` = `in_vc`, and `busy` does not change.
- R5: An accepted body whose `in_vc` is free, or is owned by a different tag, is pushed back with `push_vc` = `in_vc`.
- R6: Kind code 11 is a tail. An accepted tail that owns its VC is forwarded, and that VC's busy bit clears on the same edge that accepts the tail. A header accepted in the very next cycle may therefore claim that VC.
- R7: An accepted tail that does not own its VC is pushed back, and `busy` does not change.
- R8: Kind code 00 is a single-flit packet. It is forwarded with `fwd_vc` = `in_vc` and its kind, tag and payload unchanged, and `busy` does not change.
- R9: The outputs appear one clock edge after acceptance. After an accepted flit, exactly one of `fwd_valid` and `push_back` is 1. In a cycle that follows no acceptance, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Block can accept a flit |
| in_kind | input | 2 | Flit kind: 00 single, 01 header, 10 body, 11 tail |
| in_vc | input | VC_W | VC named by the flit |
| in_tag | input | TAG_W | Packet tag |
| in_payload | input | DATA_W | Flit payload |
| fwd_valid | output | 1 | Forwarded flit valid |
| fwd_kind | output | 2 | Kind of forwarded flit |
| fwd_vc | output | VC_W | VC the flit is forwarded on |
| fwd_tag | output | TAG_W | Tag of forwarded flit |
| fwd_payload | output | DATA_W | Payload of forwarded flit |
| push_back | output | 1 | Flit returned to its input VC |
| push_vc | output | VC_W | Input VC that receives the returned flit |
| busy | output | NUM_VC | One bit per VC, set while the VC is held |

## Verification
The bench fills every VC and checks that lowest-free selection still holds after a VC in the middle is freed. A design with a wrong priority order would forward on a higher VC. It sends a body and a tail whose tag does not match a busy VC, and a body that names a free VC. A design that compared only the VC number, or only the busy bit, would forward these flits instead of pushing them back. A header arrives while every VC is busy; a design that overwrote an owner would change `busy` or forward that header. A tail is followed at once by a header, to catch a release that lags by one cycle, and a single-flit packet is sent while every VC is busy, to show that it neither claims a VC nor stalls.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  typedef enum logic [1:0] {
    FK_SOLO = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/vcs_kind_decode.sv
module vcs_kind_decode
  import vcs_pkg::*;
(
  input  logic [1:0] kind,
  output logic       is_solo,
  output logic       is_head,
  output logic       is_body,
  output logic       is_tail
);
  flit_kind_e k;
  always_comb begin
    k       = flit_kind_e'(kind);
    is_solo = (k == FK_SOLO);
    is_head = (k == FK_HEAD);
    is_body = (k == FK_BODY);
    is_tail = (k == FK_TAIL);
  end
endmodule

// File: rtl/vcs_free_pick.sv
module vcs_free_pick #(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2
) (
  input  logic [NUM_VC-1:0] busy,
  output logic              any_free,
  output logic [VC_W-1:0]   free_idx
);
  // scan from the top so the lowest free index is the one that remains
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_idx = VC_W'(i);
      end
    end
  end
endmodule

// File: rtl/vcs_owner_table.sv
module vcs_owner_table #(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_en,
  input  logic [VC_W-1:0]   claim_idx,
  input  logic [TAG_W-1:0]  claim_tag,
  input  logic              rel_en,
  input  logic [VC_W-1:0]   rel_idx,
  input  logic [VC_W-1:0]   look_idx,
  output logic              look_busy,
  output logic [TAG_W-1:0]  look_tag,
  output logic [NUM_VC-1:0] busy
);
  logic [NUM_VC-1:0][TAG_W-1:0] owner;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_slot
    logic             held_q;
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= 1'b0;
      end else if (claim_en && claim_idx == VC_W'(g)) begin
        held_q <= 1'b1;
      end else if (rel_en && rel_idx == VC_W'(g)) begin
        held_q <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (claim_en && claim_idx == VC_W'(g)) tag_q <= claim_tag;
    end
    assign busy[g]  = held_q;
    assign owner[g] = tag_q;
  end

  assign look_busy = busy[look_idx];
  assign look_tag  = owner[look_idx];

  // R2: a claim never lands on a held channel
  p_claim_free_r2: assert property (@(posedge clk) disable iff (rst)
    claim_en |-> !busy[claim_idx]);
  // R6: a release only frees a channel that is held
  p_release_held_r6: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> busy[rel_idx]);
  p_claim_rel_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(claim_en && rel_en));
endmodule

// File: rtl/vcs_signup_ctrl.sv
module vcs_signup_ctrl #(
  parameter int NUM_VC = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_payload,
  output logic              fwd_valid,
  output logic [1:0]        fwd_kind,
  output logic [VC_W-1:0]   fwd_vc,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [DATA_W-1:0] fwd_payload,
  output logic              push_back,
  output logic [VC_W-1:0]   push_vc,
  output logic [NUM_VC-1:0] busy
);
  logic is_solo, is_head, is_body, is_tail;
  logic any_free;
  logic [VC_W-1:0] free_idx;
  logic look_busy;
  logic [TAG_W-1:0] look_tag;
  logic ready_q, accept, owns, pass, claim_en, rel_en;
  logic [VC_W-1:0] out_vc;

  vcs_kind_decode u_dec (
    .kind(in_kind), .is_solo(is_solo), .is_head(is_head),
    .is_body(is_body), .is_tail(is_tail)
  );

  vcs_free_pick #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_pick (
    .busy(busy), .any_free(any_free), .free_idx(free_idx)
  );

  vcs_owner_table #(.NUM_VC(NUM_VC), .VC_W(VC_W), .TAG_W(TAG_W)) u_tab (
    .clk(clk), .rst(rst),
    .claim_en(claim_en), .claim_idx(free_idx), .claim_tag(in_tag),
    .rel_en(rel_en), .rel_idx(in_vc),
    .look_idx(in_vc), .look_busy(look_busy), .look_tag(look_tag),
    .busy(busy)
  );

  always_comb begin
    accept   = in_valid && ready_q;
    owns     = look_busy && (look_tag == in_tag);
    pass     = is_solo || (is_head && any_free) || ((is_body || is_tail) && owns);
    claim_en = accept && is_head && any_free;
    rel_en   = accept && is_tail && owns;
    out_vc   = is_head ? free_idx : in_vc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      fwd_valid <= 1'b0;
      push_back <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      fwd_valid <= accept && pass;
      push_back <= accept && !pass;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      fwd_kind    <= in_kind;
      fwd_vc      <= out_vc;
      fwd_tag     <= in_tag;
      fwd_payload <= in_payload;
      push_vc     <= in_vc;
    end
  end

  assign in_ready = ready_q;

  // R9: one registered response per accepted flit, none otherwise
  p_one_resp_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (fwd_valid ^ push_back));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!fwd_valid && !push_back));
  // R2: a header with room adds exactly one busy channel, the one it leaves on
  p_head_claims_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && is_head && any_free) |=>
      (fwd_valid && busy[fwd_vc] && $countones(busy) == $countones($past(busy)) + 1));
  // R3: a header with no room is returned and changes nothing
  p_head_full_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && is_head && !any_free) |=> (push_back && $stable(busy)));
  // R6: an owning tail frees its channel on the accepting edge
  p_tail_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && is_tail && owns) |=> (fwd_valid && !busy[fwd_vc]));
  // R8: a single-flit packet passes and leaves ownership alone
  p_solo_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && is_solo) |=> (fwd_valid && $stable(busy)));
endmodule

// File: tb/tb_vcs_signup_ctrl.sv
module tb_vcs_signup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int TW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready;
  logic [1:0] in_kind;
  logic [1:0] in_vc;
  logic [TW-1:0] in_tag;
  logic [DW-1:0] in_payload;
  logic fwd_valid, push_back;
  logic [1:0] fwd_kind, fwd_vc, push_vc;
  logic [TW-1:0] fwd_tag;
  logic [DW-1:0] fwd_payload;
  logic [NV-1:0] busy;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcs_signup_ctrl #(.NUM_VC(NV), .TAG_W(TW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_vc(in_vc), .in_tag(in_tag), .in_payload(in_payload),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_vc(fwd_vc),
    .fwd_tag(fwd_tag), .fwd_payload(fwd_payload),
    .push_back(push_back), .push_vc(push_vc), .busy(busy)
  );

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [1:0] vc,
                       input logic [TW-1:0] tag, input logic [DW-1:0] pl);
    in_valid = 1'b1; in_kind = k; in_vc = vc; in_tag = tag; in_payload = pl;
  endtask

  // one flit, outputs sampled at the negedge after the accepting edge
  task automatic send(input logic [1:0] k, input logic [1:0] vc,
                      input logic [TW-1:0] tag, input logic [DW-1:0] pl);
    @(negedge clk);
    drive(k, vc, tag, pl);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_fwd(input string req, input int vc, input int bsy);
    chk({req, " fwd_valid"}, int'(fwd_valid), 1);
    chk({req, " push_back"}, int'(push_back), 0);
    chk({req, " fwd_vc"}, int'(fwd_vc), vc);
    chk({req, " busy"}, int'(busy), bsy);
  endtask

  task automatic expect_push(input string req, input int vc, input int bsy);
    chk({req, " push_back"}, int'(push_back), 1);
    chk({req, " fwd_valid"}, int'(fwd_valid), 0);
    chk({req, " push_vc"}, int'(push_vc), vc);
    chk({req, " busy"}, int'(busy), bsy);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; in_valid = 1'b0; in_kind = '0; in_vc = '0; in_tag = '0; in_payload = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 ready in reset", int'(in_ready), 0);
    chk("R1 fwd in reset", int'(fwd_valid), 0);
    chk("R1 push in reset", int'(push_back), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_claim_order_r2();
    send(2'b01, 2'd3, 4'd1, 32'hA001);
    expect_fwd("R2 first header", 0, 4'b0001);
    chk("R2 payload", int'(fwd_payload), 32'hA001);
    send(2'b01, 2'd0, 4'd2, 32'hA002);
    expect_fwd("R2 second header", 1, 4'b0011);
  endtask

  task automatic t_body_r4_r5();
    send(2'b10, 2'd0, 4'd1, 32'hB001);
    expect_fwd("R4 owning body", 0, 4'b0011);
    send(2'b10, 2'd0, 4'd2, 32'hB002);
    expect_push("R5 body wrong tag", 0, 4'b0011);
    send(2'b10, 2'd2, 4'd3, 32'hB003);
    expect_push("R5 body free vc", 2, 4'b0011);
  endtask

  task automatic t_tail_reclaim_r6();
    send(2'b11, 2'd0, 4'd1, 32'hC001);
    expect_fwd("R6 tail releases", 0, 4'b0010);
    send(2'b01, 2'd3, 4'd5, 32'hC002);
    expect_fwd("R6 lowest reclaim", 0, 4'b0011);
  endtask

  task automatic t_full_r3();
    send(2'b01, 2'd0, 4'd6, 32'hD001);
    expect_fwd("R2 third header", 2, 4'b0111);
    send(2'b01, 2'd0, 4'd7, 32'hD002);
    expect_fwd("R2 fourth header", 3, 4'b1111);
    send(2'b01, 2'd1, 4'd8, 32'hD003);
    expect_push("R3 header all busy", 1, 4'b1111);
  endtask

  task automatic t_solo_r8();
    send(2'b00, 2'd1, 4'd9, 32'hE001);
    expect_fwd("R8 single flit", 1, 4'b1111);
    chk("R8 kind kept", int'(fwd_kind), 0);
    chk("R8 tag kept", int'(fwd_tag), 9);
    chk("R8 payload kept", int'(fwd_payload), 32'hE001);
  endtask

  task automatic t_tail_mismatch_r7();
    send(2'b11, 2'd2, 4'd2, 32'hF001);
    expect_push("R7 tail wrong tag", 2, 4'b1111);
    send(2'b11, 2'd2, 4'd6, 32'hF002);
    expect_fwd("R6 middle release", 2, 4'b1011);
    send(2'b01, 2'd0, 4'd8, 32'hF003);
    expect_fwd("R2 refill middle", 2, 4'b1111);
  endtask

  task automatic t_back_to_back_r6();
    @(negedge clk);
    drive(2'b11, 2'd3, 4'd7, 32'h1111);
    @(negedge clk);
    expect_fwd("R6 b2b tail", 3, 4'b0111);
    drive(2'b01, 2'd0, 4'd4, 32'h2222);
    @(negedge clk);
    in_valid = 1'b0;
    expect_fwd("R6 b2b header same vc", 3, 4'b1111);
  endtask

  task automatic t_idle_r9();
    @(negedge clk);
    chk("R9 idle fwd", int'(fwd_valid), 0);
    chk("R9 idle push", int'(push_back), 0);
    chk("R9 idle busy", int'(busy), 4'b1111);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_claim_order_r2();
    t_body_r4_r5();
    t_tail_reclaim_r6();
    t_full_r3();
    t_solo_r8();
    t_tail_mismatch_r7();
    t_back_to_back_r6();
    t_idle_r9();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule